// File: doc/BRIEF.md
# I2C Byte Transfer Engine with Selectable Interrupt Point

This block is the per-byte part of an I2C interface. Once a START or repeated START has been detected elsewhere, it counts SCL clock cycles within each byte. It shifts received bits in, or drives transmit bits out, and raises a transfer-complete interrupt flag. While that flag is pending, the block holds SCL low so the remote master waits. Software clears the flag to let the bus run again.

When receiving data, software can move the interrupt point forward. The interrupt then comes after the eighth SCL cycle, before the acknowledge slot. Software can read the byte, check it (a packet checksum, for example) and then pick ACK or NACK with the acknowledge-enable input before releasing SCL. When transmitting, or while the first (address) byte is on the bus, the interrupt always comes after the ninth cycle. START detection, address compare, arbitration and clock generation belong to neighbouring blocks.

The controlling state machine has three states. PH_IDLE waits for the first START. PH_DATA covers the eight data cycles of a byte. PH_ACK covers the acknowledge cycle. The transitions are:
- IDLE_TO_DATA on a START.
- DATA_TO_ACK on the SCL falling edge that ends cycle 8.
- ACK_TO_DATA on the SCL falling edge that ends cycle 9.
- RESTART from any state back to PH_DATA with the cycle count cleared, on a START or repeated START.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, irq_flag, scl_hold and sda_low are 0, rx_data is 0 and last_ack is 1.
- R2: A start_det pulse clears the SCL cycle count to 0, even in the middle of a byte. After each START, the next eight SCL rising edges are the data cycles of a new byte. A byte ends at the ninth cycle, and the count then continues at cycle 1 of the following byte.
- R3: On each SCL rising edge of cycles 1 to 8, sda_in is shifted into rx_data at bit 0, so the first bit received ends in bit 7 (MSB first).
- R4: With early_irq_sel = 0, irq_flag is set on the SCL falling edge that ends cycle 9, and it is not set at the end of cycle 8.
- R5: With early_irq_sel = 1, tx_mode = 0 and first_byte = 0, irq_flag is set on the falling edge that ends cycle 8, and no interrupt is raised at the end of cycle 9.
- R6: With tx_mode = 1 or first_byte = 1, the interrupt comes only at the end of cycle 9, whatever early_irq_sel says.
- R7: If early_irq_sel is cleared while a cycle-8 interrupt is pending, a second interrupt is raised at the end of cycle 9 of the same byte.
- R8: In receive mode, during the low phase before cycle 9 and through its high phase, sda_low equals ack_en (1 pulls SDA low, meaning ACK). The value is taken from ack_en while SCL is still low, so an ack_en written during a cycle-8 interrupt takes effect. sda_low returns to 0 after the ninth falling edge.
- R9: last_ack captures sda_in on the SCL rising edge of cycle 9 (0 means ACK) and keeps it until the next cycle 9.
- R10: irq_flag stays 1 until an irq_clr pulse. scl_hold is 1 exactly while irq_flag is 1.
- R11: In transmit mode, sda_low is the inverse of tx_data bit (7 minus the data cycle index), MSB first, for each data cycle. sda_low is 0 during cycle 9.
- R12: sda_low changes only when SCL has been low on two consecutive clock samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| start_det | input | 1 | One-cycle pulse on START or repeated START |
| tx_mode | input | 1 | 1 = this side transmits the byte |
| first_byte | input | 1 | 1 = address byte phase |
| early_irq_sel | input | 1 | 1 = interrupt at cycle 8 when receiving data |
| ack_en | input | 1 | 1 = drive ACK in cycle 9 when receiving |
| tx_data | input | BYTE_W | Byte to transmit |
| irq_clr | input | 1 | Pulse clearing the interrupt flag |
| sda_low | output | 1 | 1 = pull SDA low |
| rx_data | output | BYTE_W | Received shift register |
| last_ack | output | 1 | SDA level seen in cycle 9 |
| irq_flag | output | 1 | Transfer-complete interrupt pending |
| scl_hold | output | 1 | 1 = hold SCL low |

## Verification
The bound checker watches every cycle for several properties. It checks that SDA output changes happen only during a settled SCL low phase, and that the interrupt rises only on cycle 8 or cycle 9. It also checks that an interrupt in transmit or address phase comes only at cycle 9, that a pending flag survives until it is cleared, and that a START clears the cycle count. Other behaviour depends on software acting in the middle of a byte, and only the bench scenarios can show it. This covers the data-dependent ACK chosen after a cycle-8 interrupt, the second interrupt after the select bit is dropped, MSB-first shifting in both directions, and recovery from a repeated START partway through a byte.

// File: rtl/i2c_byte_pkg.sv
package i2c_byte_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_ACK  = 2'd2
    } phase_t;

endpackage

// File: rtl/i2c_scl_edge.sv
module i2c_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise,
    output logic fall,
    output logic low_settled
);

    logic line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_in;
    end

    assign rise        = line_in & ~line_q;
    assign fall        = ~line_in & line_q;
    assign low_settled = ~line_in & ~line_q;

endmodule

// File: rtl/i2c_bit_counter.sv
module i2c_bit_counter #(
    parameter int SLOTS = 9,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] LAST = CW'(SLOTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (clear)   count <= '0;
        else if (step)    count <= (count == LAST) ? CW'(1) : count + CW'(1);
    end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_det,
    input  logic              tx_mode,
    input  logic              first_byte,
    input  logic              early_irq_sel,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              irq_clr,
    output logic              sda_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              last_ack,
    output logic              irq_flag,
    output logic              scl_hold
);
    import i2c_byte_pkg::*;

    localparam int SLOTS = BYTE_W + 1;
    localparam int CW    = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] CNT_DATA_END = CW'(BYTE_W);
    localparam logic [CW-1:0] CNT_ACK_END  = CW'(SLOTS);

    phase_t          phase, phase_nxt;
    logic            scl_rise, scl_fall, scl_low;
    logic [CW-1:0]   bit_cnt;
    logic            rx_early;
    logic            irq_set;
    logic            sda_nxt;
    logic [CW-1:0]   tx_idx;
    logic [BYTE_W-1:0] tx_shifted;

    i2c_scl_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (scl_in),
        .rise        (scl_rise),
        .fall        (scl_fall),
        .low_settled (scl_low)
    );

    i2c_bit_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_det),
        .step  (scl_rise && (phase != PH_IDLE)),
        .count (bit_cnt)
    );

    // early point applies only to plain data reception
    assign rx_early = early_irq_sel & ~tx_mode & ~first_byte;

    always_comb begin
        phase_nxt = phase;
        if (start_det) begin
            phase_nxt = PH_DATA;
        end else begin
            unique case (phase)
                PH_IDLE: phase_nxt = PH_IDLE;
                PH_DATA: if (scl_fall && bit_cnt == CNT_DATA_END) phase_nxt = PH_ACK;
                PH_ACK:  if (scl_fall && bit_cnt == CNT_ACK_END)  phase_nxt = PH_DATA;
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    assign irq_set = scl_fall && !start_det &&
                     (((phase == PH_DATA) && (bit_cnt == CNT_DATA_END) && rx_early) ||
                      ((phase == PH_ACK)  && (bit_cnt == CNT_ACK_END)  && !rx_early));

    // after the acknowledge cycle the count sits at SLOTS: next bit is the MSB
    assign tx_idx     = (bit_cnt >= CNT_DATA_END) ? '0 : bit_cnt;
    assign tx_shifted = tx_data << tx_idx;

    always_comb begin
        sda_nxt = 1'b0;
        unique case (phase)
            PH_IDLE: sda_nxt = 1'b0;
            PH_DATA: sda_nxt = tx_mode & ~tx_shifted[BYTE_W-1];
            PH_ACK:  sda_nxt = ~tx_mode & ack_en;
            default: sda_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low  <= 1'b0;
            rx_data  <= '0;
            last_ack <= 1'b1;
            irq_flag <= 1'b0;
        end else begin
            if (scl_low)
                sda_low <= sda_nxt;
            if (scl_rise && phase == PH_DATA)
                rx_data <= {rx_data[BYTE_W-2:0], sda_in};
            if (scl_rise && phase == PH_ACK)
                last_ack <= sda_in;
            if (irq_set)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;
        end
    end

    assign scl_hold = irq_flag;

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk #(
    parameter int BYTE_W = 8,
    localparam int SLOTS = BYTE_W + 1,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          start_det,
    input logic          tx_mode,
    input logic          first_byte,
    input logic          irq_clr,
    input logic          sda_low,
    input logic          irq_flag,
    input logic [CW-1:0] bit_cnt
);

    AST_SDA_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> (!$past(scl_in) && !$past(scl_in, 2))); // R12

    AST_IRQ_AT_END_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(bit_cnt) == CW'(BYTE_W) || $past(bit_cnt) == CW'(SLOTS))); // R4

    AST_LATE_IRQ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_flag) && $past(tx_mode || first_byte)) |-> ($past(bit_cnt) == CW'(SLOTS))); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R10

    AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bit_cnt == '0)); // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(SLOTS)); // R2

endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .start_det  (start_det),
    .tx_mode    (tx_mode),
    .first_byte (first_byte),
    .irq_clr    (irq_clr),
    .sda_low    (sda_low),
    .irq_flag   (irq_flag),
    .bit_cnt    (bit_cnt)
);

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_bus = 1'b1;
    logic       sda_in;
    logic       start_det = 1'b0;
    logic       tx_mode = 1'b0;
    logic       first_byte = 1'b0;
    logic       early_irq_sel = 1'b0;
    logic       ack_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic       sda_low;
    logic [7:0] rx_data;
    logic       last_ack;
    logic       irq_flag;
    logic       scl_hold;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wired-AND bus: the device pulls low over the bench level
    assign sda_in = sda_bus & ~sda_low;

    i2c_byte_engine #(.BYTE_W(8)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_in),
        .start_det     (start_det),
        .tx_mode       (tx_mode),
        .first_byte    (first_byte),
        .early_irq_sel (early_irq_sel),
        .ack_en        (ack_en),
        .tx_data       (tx_data),
        .irq_clr       (irq_clr),
        .sda_low       (sda_low),
        .rx_data       (rx_data),
        .last_ack      (last_ack),
        .irq_flag      (irq_flag),
        .scl_hold      (scl_hold)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic scl_up();
        while (scl_hold) @(negedge clk);
        scl = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic scl_down();
        scl = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        scl = 1'b1;
        repeat (2) @(negedge clk);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        scl_down();
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_bus = v[i];
            @(negedge clk);
            scl_up();
            scl_down();
        end
        sda_bus = 1'b1;
    endtask

    task automatic ack_slot(logic bus, output logic drv_high);
        sda_bus = bus;
        @(negedge clk);
        scl_up();
        drv_high = sda_low;
        scl_down();
        sda_bus = 1'b1;
    endtask

    task automatic sw_clear();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq_flag", {7'd0, irq_flag}, 8'd0);
        chk("R1 scl_hold", {7'd0, scl_hold}, 8'd0);
        chk("R1 sda_low", {7'd0, sda_low}, 8'd0);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 last_ack", {7'd0, last_ack}, 8'd1);
    endtask

    task automatic t_rx_default();
        logic d;
        tx_mode = 0; first_byte = 0; early_irq_sel = 0; ack_en = 1;
        do_start();
        send_bits(8'hA5, 8);
        chk("R4 no irq at cycle 8", {7'd0, irq_flag}, 8'd0);
        chk("R8 ack prepared", {7'd0, sda_low}, 8'd1);
        ack_slot(1'b1, d);
        chk("R8 ack held in cycle 9", {7'd0, d}, 8'd1);
        chk("R4 irq at cycle 9", {7'd0, irq_flag}, 8'd1);
        chk("R3 rx byte", rx_data, 8'hA5);
        chk("R9 ack seen", {7'd0, last_ack}, 8'd0);
        chk("R8 released after 9", {7'd0, sda_low}, 8'd0);
        repeat (6) @(negedge clk);
        chk("R10 flag persists", {7'd0, irq_flag}, 8'd1);
        chk("R10 hold while pending", {7'd0, scl_hold}, 8'd1);
        sw_clear();
        chk("R10 flag cleared", {7'd0, irq_flag}, 8'd0);
        chk("R10 hold released", {7'd0, scl_hold}, 8'd0);
    endtask

    task automatic t_rx_early_ack();
        logic d;
        tx_mode = 0; first_byte = 0; early_irq_sel = 1; ack_en = 0;
        do_start();
        send_bits(8'h3C, 8);
        chk("R5 irq at cycle 8", {7'd0, irq_flag}, 8'd1);
        chk("R5 byte readable", rx_data, 8'h3C);
        chk("R10 hold at cycle 8", {7'd0, scl_hold}, 8'd1);
        chk("R8 nack level before choice", {7'd0, sda_low}, 8'd0);
        ack_en = 1;
        sw_clear();
        chk("R8 ack after choice", {7'd0, sda_low}, 8'd1);
        ack_slot(1'b1, d);
        chk("R8 ack through cycle 9", {7'd0, d}, 8'd1);
        chk("R5 no irq at cycle 9", {7'd0, irq_flag}, 8'd0);
        chk("R8 released before next byte", {7'd0, sda_low}, 8'd0);
    endtask

    task automatic t_rx_early_nack();
        logic d;
        tx_mode = 0; first_byte = 0; early_irq_sel = 1; ack_en = 1;
        do_start();
        send_bits(8'h81, 8);
        chk("R5 irq at cycle 8 nack case", {7'd0, irq_flag}, 8'd1);
        ack_en = 0;
        sw_clear();
        ack_slot(1'b1, d);
        chk("R8 nack in cycle 9", {7'd0, d}, 8'd0);
        chk("R9 nack seen", {7'd0, last_ack}, 8'd1);
        chk("R5 no second irq", {7'd0, irq_flag}, 8'd0);
    endtask

    task automatic t_reselect();
        logic d;
        tx_mode = 0; first_byte = 0; early_irq_sel = 1; ack_en = 1;
        do_start();
        send_bits(8'hC3, 8);
        chk("R7 first irq at 8", {7'd0, irq_flag}, 8'd1);
        early_irq_sel = 0;
        sw_clear();
        ack_slot(1'b1, d);
        chk("R7 second irq at 9", {7'd0, irq_flag}, 8'd1);
        chk("R9 ack valid at 9", {7'd0, last_ack}, 8'd0);
        sw_clear();
    endtask

    task automatic t_first_byte();
        logic d;
        tx_mode = 0; first_byte = 1; early_irq_sel = 1; ack_en = 1;
        do_start();
        send_bits(8'hA0, 8);
        chk("R6 no early irq in address byte", {7'd0, irq_flag}, 8'd0);
        ack_slot(1'b1, d);
        chk("R6 irq at 9 in address byte", {7'd0, irq_flag}, 8'd1);
        chk("R3 address byte", rx_data, 8'hA0);
        sw_clear();
        first_byte = 0;
    endtask

    task automatic tx_byte(logic [7:0] v, logic ack_bus, string tag);
        logic d;
        for (int i = 7; i >= 0; i--) begin
            sda_bus = 1'b1;
            @(negedge clk);
            scl_up();
            chk({"R11 tx bit ", tag}, {7'd0, sda_low}, {7'd0, ~v[i]});
            scl_down();
        end
        chk({"R6 no early irq in tx ", tag}, {7'd0, irq_flag}, 8'd0);
        ack_slot(ack_bus, d);
        chk({"R11 released in cycle 9 ", tag}, {7'd0, d}, 8'd0);
        chk({"R6 irq at 9 in tx ", tag}, {7'd0, irq_flag}, 8'd1);
        chk({"R9 last_ack ", tag}, {7'd0, last_ack}, {7'd0, ack_bus});
    endtask

    task automatic t_transmit();
        tx_mode = 1; first_byte = 0; early_irq_sel = 1; ack_en = 1;
        tx_data = 8'h96;
        do_start();
        tx_byte(8'h96, 1'b0, "b0");
        tx_data = 8'h5A;
        sw_clear();
        tx_byte(8'h5A, 1'b1, "b1");
        sw_clear();
        tx_mode = 0;
    endtask

    task automatic t_restart();
        logic d;
        tx_mode = 0; first_byte = 0; early_irq_sel = 0; ack_en = 1;
        do_start();
        send_bits(8'hE0, 3);
        do_start();
        send_bits(8'h42, 8);
        chk("R2 count restarted, no irq yet", {7'd0, irq_flag}, 8'd0);
        ack_slot(1'b1, d);
        chk("R2 irq after fresh byte", {7'd0, irq_flag}, 8'd1);
        chk("R2 byte after restart", rx_data, 8'h42);
        sw_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rx_default();
        t_rx_early_ack();
        t_rx_early_nack();
        t_reselect();
        t_first_byte();
        t_transmit();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule